// File: doc/BRIEF.md
# Three-Pulse RR Interval Rhythm Classifier

The block watches a one-bit stream that marks detected R peaks and grades heart rhythm from the spacing of consecutive beats. Time is measured in sample ticks: a tick enable is high for one clock cycle per ECG sample, which is 1 ms at a 1 kHz sample rate. The R-peak flag is read only on tick cycles. The block locks onto the first peak it sees. From then on it holds a window of the three most recent peaks, and the window slides forward by one peak at every new beat.

Each window holds two adjacent RR intervals and the span across both. The block marks the window arrhythmic when the earlier interval is short compared with that span. It marks the window tachycardic or bradycardic when either interval lies outside fixed rate limits. Four saturating counters record beats, arrhythmic windows, tachycardic windows and bradycardic windows. Each counter is also shown as two decimal digits in seven-segment form. The three interval values of the current window are brought out for inspection. An end-of-data strobe freezes the block until the next reset.

Top module: `rr_rhythm_classifier`

## Requirements
- R1: While `rst_n` is low at a clock edge, all four counts and all three interval outputs become 0, and every digit output shows the zero pattern 7'h40.
- R2: A beat is a clock cycle with both `tick` and `r_pulse` high. Each beat raises `qrs_count` by one. A high `r_pulse` without `tick` is ignored. A `tick` without `r_pulse` changes no count.
- R3: The interval of a beat is the number of ticks after the previous beat, up to and including the beat's own tick. The value saturates at 16'hFFFF. No ticks are counted before the first beat.
- R4: From the second beat onward, each beat moves the old `second_ticks` into `first_ticks` and loads the new interval into `second_ticks`. It sets `span_ticks` to the saturating sum of the two. All outputs update on the clock edge that samples the beat.
- R5: No window is classified before the third beat.
- R6: From the third beat on, the window is counted as arrhythmic when 10 × `first_ticks` < 4 × `span_ticks`, with strict comparison on the updated values.
- R7: From the third beat on, the window adds one to `tachy_count` when either interval is below 429 ticks (a rate above 140 bpm).
- R8: From the third beat on, the window adds one to `brady_count` when either interval is above 1500 ticks (a rate below 40 bpm). One window may count as both tachycardic and bradycardic.
- R9: Every count stops at 99 and stays there.
- R10: A high `end_of_data` freezes all counts and interval outputs until reset. This includes a beat in the same cycle as the strobe.
- R11: Each digit is active-low with segments g..a in bits 6..0. The tens digit shows count/10 and the ones digit shows count mod 10. The patterns for digits 0 through 9 are 40, 79, 24, 30, 19, 12, 02, 78, 00 and 10 in hex.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle sample tick |
| r_pulse | input | 1 | R-peak flag, read on tick cycles |
| end_of_data | input | 1 | Freezes the block until reset |
| qrs_count | output | 8 | Beats seen |
| arr_count | output | 8 | Arrhythmic windows |
| tachy_count | output | 8 | Tachycardic windows |
| brady_count | output | 8 | Bradycardic windows |
| qrs_seg_tens | output | 7 | Tens digit of qrs_count |
| qrs_seg_ones | output | 7 | Ones digit of qrs_count |
| arr_seg_tens | output | 7 | Tens digit of arr_count |
| arr_seg_ones | output | 7 | Ones digit of arr_count |
| tachy_seg_tens | output | 7 | Tens digit of tachy_count |
| tachy_seg_ones | output | 7 | Ones digit of tachy_count |
| brady_seg_tens | output | 7 | Tens digit of brady_count |
| brady_seg_ones | output | 7 | Ones digit of brady_count |
| first_ticks | output | 16 | Earlier interval of the window |
| second_ticks | output | 16 | Later interval of the window |
| span_ticks | output | 16 | Span across the three pulses |

## Verification
The bench places intervals right at the limits. It uses 428 against 429 and 1500 against 1501. It also builds an arrhythmia pair whose products are exactly equal (40 then 60). A design that used a non-strict comparison, or that was off by one in the interval count, would shift a count on exactly these beats. A gap longer than 65535 ticks shows whether the interval and the span saturate rather than wrap. A hundred fast regular beats drive the beat count and the tachycardia count into their cap of 99.

The bench also checks the first two beats, where a design that classifies too early would raise counts. It checks a peak flag without a tick and a beat in the same cycle as the end-of-data strobe; a design that let either through would change its outputs. Random gap sequences with tick spacings of one and two cycles are compared against a reference model in the bench.

// File: rtl/rr_pkg.sv
// Shared constants and the seven-segment digit encoder for the rhythm classifier.
package rr_pkg;

    localparam int NUM_CNT   = 4;
    localparam int IDX_QRS   = 0;
    localparam int IDX_ARR   = 1;
    localparam int IDX_TACHY = 2;
    localparam int IDX_BRADY = 3;

    // Active-low seven-segment pattern, g..a in bits 6..0; a code above 9 blanks the digit.
    function automatic logic [6:0] seg7_n(input logic [3:0] digit);
        logic [6:0] pat;
        case (digit)
            4'd0:    pat = 7'h40;
            4'd1:    pat = 7'h79;
            4'd2:    pat = 7'h24;
            4'd3:    pat = 7'h30;
            4'd4:    pat = 7'h19;
            4'd5:    pat = 7'h12;
            4'd6:    pat = 7'h02;
            4'd7:    pat = 7'h78;
            4'd8:    pat = 7'h00;
            4'd9:    pat = 7'h10;
            default: pat = 7'h7F;
        endcase
        return pat;
    endfunction

endpackage

// File: rtl/rr_interval_window.sv
// Measures tick intervals between beats and keeps the three-pulse window.
// Assumes `beat` and `tick_run` already carry the halt gating. Ticks are
// counted only after the first beat has locked the window. The interval
// and the span saturate at all ones.
module rr_interval_window #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_run,
    input  logic          beat,
    output logic [TW-1:0] first_q,
    output logic [TW-1:0] second_q,
    output logic [TW-1:0] span_q,
    output logic [TW-1:0] nxt_first,
    output logic [TW-1:0] nxt_second,
    output logic [TW-1:0] nxt_span,
    output logic          classify
);
    localparam logic [TW-1:0] TMAX = {TW{1'b1}};

    logic [TW-1:0] gap_cnt;
    logic [TW-1:0] gap_inc;
    logic [1:0]    seen;
    logic [TW:0]   sum_wide;

    // Saturating increment of the running gap and assembly of the next window.
    always_comb begin
        gap_inc    = (gap_cnt == TMAX) ? TMAX : gap_cnt + 1'b1;
        nxt_first  = second_q;
        nxt_second = gap_inc;
        sum_wide   = {1'b0, nxt_first} + {1'b0, nxt_second};
        nxt_span   = sum_wide[TW] ? TMAX : sum_wide[TW-1:0];
        classify   = beat && (seen == 2'd2);
    end

    // Gap counting, lock tracking and window shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt  <= '0;
            seen     <= '0;
            first_q  <= '0;
            second_q <= '0;
            span_q   <= '0;
        end else if (beat) begin
            gap_cnt <= '0;
            seen    <= (seen == 2'd2) ? 2'd2 : seen + 2'd1;
            if (seen != 2'd0) begin
                first_q  <= nxt_first;
                second_q <= nxt_second;
                span_q   <= nxt_span;
            end
        end else if (tick_run && (seen != 2'd0)) begin
            gap_cnt <= gap_inc;
        end
    end

    // R4: window outputs move only on a beat
    a_r4_window_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !beat |=> ($stable(first_q) && $stable(second_q) && $stable(span_q)));

    // R3: a beat right after the previous one measures exactly one tick
    a_r3_one_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && seen != 2'd0) |=> (!beat || gap_cnt == '0));

endmodule

// File: rtl/rr_rhythm_judge.sv
// Grades one window: short first interval against the span (arrhythmia),
// either interval under the fast limit or over the slow limit. The
// comparison is done without division. The caller qualifies the results
// with its classify strobe.
module rr_rhythm_judge #(
    parameter int TW          = 16,
    parameter int TACHY_LIMIT = 429,
    parameter int BRADY_LIMIT = 1500
) (
    input  logic [TW-1:0] first_iv,
    input  logic [TW-1:0] second_iv,
    input  logic [TW-1:0] span_iv,
    output logic          is_arr,
    output logic          is_tachy,
    output logic          is_brady
);
    localparam int PW = TW + 4;

    logic [PW-1:0] lhs;
    logic [PW-1:0] rhs;

    // Scaled comparison 10*first < 4*span and the two rate limits.
    always_comb begin
        lhs      = PW'(first_iv) * PW'(10);
        rhs      = PW'(span_iv) * PW'(4);
        is_arr   = lhs < rhs;
        is_tachy = (first_iv < TW'(TACHY_LIMIT)) || (second_iv < TW'(TACHY_LIMIT));
        is_brady = (first_iv > TW'(BRADY_LIMIT)) || (second_iv > TW'(BRADY_LIMIT));
    end

endmodule

// File: rtl/rr_sat_counter.sv
// Event counter that stops at CAP. Assumes CAP fits in W bits.
module rr_sat_counter #(
    parameter int W   = 8,
    parameter int CAP = 99
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] value
);
    // Count up on inc and hold at the cap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            value <= '0;
        else if (inc && value != W'(CAP))
            value <= value + 1'b1;
    end

    // R9: the cap is never exceeded
    a_r9_cap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && value == W'(CAP)) |=> value == W'(CAP));

    // R2: no increment request, no change
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(value));

endmodule

// File: rtl/rr_bcd_seg.sv
// Splits a count of at most 99 into two active-low seven-segment digits.
module rr_bcd_seg #(
    parameter int W = 8
) (
    input  logic [W-1:0] value,
    output logic [6:0]   tens_n,
    output logic [6:0]   ones_n
);
    import rr_pkg::*;

    logic [3:0] tens_d;
    logic [3:0] ones_d;

    // Decimal split and pattern lookup.
    always_comb begin
        tens_d = 4'(value / W'(10));
        ones_d = 4'(value % W'(10));
        tens_n = seg7_n(tens_d);
        ones_n = seg7_n(ones_d);
    end

endmodule

// File: rtl/rr_rhythm_classifier.sv
// Top level: gates beats with the tick and the halt state, measures the
// three-pulse window, grades it, and keeps four saturating counts with
// their seven-segment digits. Assumes r_pulse is meaningful only on tick cycles.
module rr_rhythm_classifier #(
    parameter int TW          = 16,
    parameter int CW          = 8,
    parameter int CNT_CAP     = 99,
    parameter int TACHY_LIMIT = 429,
    parameter int BRADY_LIMIT = 1500
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          r_pulse,
    input  logic          end_of_data,
    output logic [CW-1:0] qrs_count,
    output logic [CW-1:0] arr_count,
    output logic [CW-1:0] tachy_count,
    output logic [CW-1:0] brady_count,
    output logic [6:0]    qrs_seg_tens,
    output logic [6:0]    qrs_seg_ones,
    output logic [6:0]    arr_seg_tens,
    output logic [6:0]    arr_seg_ones,
    output logic [6:0]    tachy_seg_tens,
    output logic [6:0]    tachy_seg_ones,
    output logic [6:0]    brady_seg_tens,
    output logic [6:0]    brady_seg_ones,
    output logic [TW-1:0] first_ticks,
    output logic [TW-1:0] second_ticks,
    output logic [TW-1:0] span_ticks
);
    import rr_pkg::*;

    logic               done;
    logic               run;
    logic               beat;
    logic               tick_run;
    logic               classify;
    logic [TW-1:0]      nxt_first, nxt_second, nxt_span;
    logic               is_arr, is_tachy, is_brady;
    logic [NUM_CNT-1:0] inc;
    logic [CW-1:0]      cnt_val [NUM_CNT];
    logic [6:0]         seg_t   [NUM_CNT];
    logic [6:0]         seg_o   [NUM_CNT];

    // Sticky halt once the data stream has ended.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done <= 1'b0;
        else if (end_of_data)
            done <= 1'b1;
    end

    // Beat and tick qualification plus the counter increment requests.
    always_comb begin
        run            = !done && !end_of_data;
        tick_run       = tick && run;
        beat           = tick_run && r_pulse;
        inc[IDX_QRS]   = beat;
        inc[IDX_ARR]   = classify && is_arr;
        inc[IDX_TACHY] = classify && is_tachy;
        inc[IDX_BRADY] = classify && is_brady;
    end

    rr_interval_window #(.TW(TW)) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_run   (tick_run),
        .beat       (beat),
        .first_q    (first_ticks),
        .second_q   (second_ticks),
        .span_q     (span_ticks),
        .nxt_first  (nxt_first),
        .nxt_second (nxt_second),
        .nxt_span   (nxt_span),
        .classify   (classify)
    );

    rr_rhythm_judge #(
        .TW          (TW),
        .TACHY_LIMIT (TACHY_LIMIT),
        .BRADY_LIMIT (BRADY_LIMIT)
    ) u_judge (
        .first_iv  (nxt_first),
        .second_iv (nxt_second),
        .span_iv   (nxt_span),
        .is_arr    (is_arr),
        .is_tachy  (is_tachy),
        .is_brady  (is_brady)
    );

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        rr_sat_counter #(.W(CW), .CAP(CNT_CAP)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (inc[g]),
            .value (cnt_val[g])
        );
        rr_bcd_seg #(.W(CW)) u_seg (
            .value  (cnt_val[g]),
            .tens_n (seg_t[g]),
            .ones_n (seg_o[g])
        );
    end

    assign qrs_count      = cnt_val[IDX_QRS];
    assign arr_count      = cnt_val[IDX_ARR];
    assign tachy_count    = cnt_val[IDX_TACHY];
    assign brady_count    = cnt_val[IDX_BRADY];
    assign qrs_seg_tens   = seg_t[IDX_QRS];
    assign qrs_seg_ones   = seg_o[IDX_QRS];
    assign arr_seg_tens   = seg_t[IDX_ARR];
    assign arr_seg_ones   = seg_o[IDX_ARR];
    assign tachy_seg_tens = seg_t[IDX_TACHY];
    assign tachy_seg_ones = seg_o[IDX_TACHY];
    assign brady_seg_tens = seg_t[IDX_BRADY];
    assign brady_seg_ones = seg_o[IDX_BRADY];

    // R10: after the halt, counts and window stay frozen
    a_r10_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ($stable(qrs_count) && $stable(arr_count) && $stable(span_ticks)));

    // R5: graded counts move only on a classified window
    a_r5_grade_needs_window: assert property (@(posedge clk) disable iff (!rst_n)
        !classify |=> ($stable(arr_count) && $stable(tachy_count) && $stable(brady_count)));

endmodule

// File: tb/rr_rhythm_classifier_test.sv
// Self-checking bench: directed limit cases plus seeded random gap sequences.
module rr_rhythm_classifier_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        r_pulse = 1'b0;
    logic        end_of_data = 1'b0;
    logic [7:0]  qrs_count, arr_count, tachy_count, brady_count;
    logic [6:0]  qrs_seg_tens, qrs_seg_ones, arr_seg_tens, arr_seg_ones;
    logic [6:0]  tachy_seg_tens, tachy_seg_ones, brady_seg_tens, brady_seg_ones;
    logic [15:0] first_ticks, second_ticks, span_ticks;

    int compared = 0;
    int mismatched = 0;

    // reference model state
    int m_qrs = 0, m_arr = 0, m_ta = 0, m_br = 0, m_seen = 0;
    int m_first = 0, m_second = 0, m_span = 0;

    always #5 clk = ~clk;

    rr_rhythm_classifier uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .r_pulse(r_pulse), .end_of_data(end_of_data),
        .qrs_count(qrs_count), .arr_count(arr_count), .tachy_count(tachy_count), .brady_count(brady_count),
        .qrs_seg_tens(qrs_seg_tens), .qrs_seg_ones(qrs_seg_ones),
        .arr_seg_tens(arr_seg_tens), .arr_seg_ones(arr_seg_ones),
        .tachy_seg_tens(tachy_seg_tens), .tachy_seg_ones(tachy_seg_ones),
        .brady_seg_tens(brady_seg_tens), .brady_seg_ones(brady_seg_ones),
        .first_ticks(first_ticks), .second_ticks(second_ticks), .span_ticks(span_ticks)
    );

    function automatic logic [6:0] exp_seg(input int d);
        case (d)
            0: return 7'h40; 1: return 7'h79; 2: return 7'h24; 3: return 7'h30;
            4: return 7'h19; 5: return 7'h12; 6: return 7'h02; 7: return 7'h78;
            8: return 7'h00; 9: return 7'h10;
            default: return 7'h7F;
        endcase
    endfunction

    function automatic int sat(input int v, input int cap);
        return (v > cap) ? cap : v;
    endfunction

    task automatic chk(input string what, input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // R11 digits, R2/R6-R9 counts, R3/R4 window values
    task automatic check_all(input string tag);
        chk({tag, " qrs"},   "R2", qrs_count, m_qrs);
        chk({tag, " arr"},   "R6", arr_count, m_arr);
        chk({tag, " tachy"}, "R7", tachy_count, m_ta);
        chk({tag, " brady"}, "R8", brady_count, m_br);
        chk({tag, " first"},  "R4", first_ticks, m_first);
        chk({tag, " second"}, "R3", second_ticks, m_second);
        chk({tag, " span"},   "R4", span_ticks, m_span);
        chk({tag, " qrs tens"},   "R11", qrs_seg_tens,   exp_seg(m_qrs / 10));
        chk({tag, " qrs ones"},   "R11", qrs_seg_ones,   exp_seg(m_qrs % 10));
        chk({tag, " arr tens"},   "R11", arr_seg_tens,   exp_seg(m_arr / 10));
        chk({tag, " arr ones"},   "R11", arr_seg_ones,   exp_seg(m_arr % 10));
        chk({tag, " tachy tens"}, "R11", tachy_seg_tens, exp_seg(m_ta / 10));
        chk({tag, " tachy ones"}, "R11", tachy_seg_ones, exp_seg(m_ta % 10));
        chk({tag, " brady tens"}, "R11", brady_seg_tens, exp_seg(m_br / 10));
        chk({tag, " brady ones"}, "R11", brady_seg_ones, exp_seg(m_br % 10));
    endtask

    // Model update for one beat with interval gap (R3-R9)
    task automatic model_beat(input int gap);
        int d;
        d = sat(gap, 65535);
        m_qrs = sat(m_qrs + 1, 99);
        if (m_seen >= 1) begin
            m_first  = m_second;
            m_second = d;
            m_span   = sat(m_first + m_second, 65535);
            if (m_seen >= 2) begin                       // R5
                if (10 * m_first < 4 * m_span) m_arr = sat(m_arr + 1, 99);
                if (m_first < 429 || m_second < 429) m_ta = sat(m_ta + 1, 99);
                if (m_first > 1500 || m_second > 1500) m_br = sat(m_br + 1, 99);
            end
        end
        m_seen = sat(m_seen + 1, 2);
    endtask

    // Issues gap ticks spaced period clocks apart; the last one carries the peak.
    task automatic beat_after(input int gap, input int period);
        for (int k = 1; k <= gap; k++) begin
            tick = 1'b1;
            r_pulse = (k == gap);
            @(negedge clk);
            if (period > 1) begin
                tick = 1'b0;
                r_pulse = 1'b0;
                repeat (period - 1) @(negedge clk);
            end
        end
        tick = 1'b0;
        r_pulse = 1'b0;
        model_beat(gap);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'd424242);
        repeat (5) @(negedge clk);
        check_all("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after release");

        // R2: peak flag without tick is ignored
        r_pulse = 1'b1;
        @(negedge clk);
        r_pulse = 1'b0;
        check_all("R2 no tick");

        // R5: first two beats lock without grading, even at a fast rate
        beat_after(5, 3);
        check_all("R5 beat1");
        beat_after(40, 3);
        check_all("R5 beat2");
        // R6: 10*40 == 4*100, strict compare -> not arrhythmic
        beat_after(60, 2);
        check_all("R6 equal boundary");
        // R6: 10*60 < 4*151 -> arrhythmic
        beat_after(91, 2);
        check_all("R6 just short");
        // R7: 429 is not tachycardic
        beat_after(429, 1);
        check_all("R7 429");
        beat_after(429, 2);
        check_all("R7 429 pair");
        beat_after(1500, 1);
        check_all("R8 1500");
        beat_after(1501, 1);
        check_all("R8 1501");
        beat_after(1000, 1);
        check_all("R8 after slow");
        beat_after(428, 1);
        check_all("R7 428");

        // random gap sequences (R3-R8)
        for (int n = 0; n < 25; n++) begin
            int cat;
            int gap;
            cat = $urandom_range(0, 3);
            case (cat)
                0: gap = $urandom_range(20, 428);
                1: gap = $urandom_range(429, 1500);
                2: gap = $urandom_range(1501, 1900);
                default: gap = $urandom_range(5, 120);
            endcase
            beat_after(gap, $urandom_range(1, 2));
            check_all("random");
        end

        // R9: fast regular beats push qrs and tachy to the cap
        for (int n = 0; n < 100; n++) begin
            beat_after(100, 1);
        end
        check_all("R9 cap");
        beat_after(100, 1);
        check_all("R9 held");

        // R3: long gap saturates the interval and the span
        beat_after(65600, 1);
        check_all("R3 saturate");
        beat_after(300, 1);
        check_all("R3 after saturate");

        // R10: beat in the strobe cycle and later beats are ignored
        end_of_data = 1'b1;
        tick = 1'b1;
        r_pulse = 1'b1;
        @(negedge clk);
        end_of_data = 1'b0;
        tick = 1'b0;
        r_pulse = 1'b0;
        check_all("R10 strobe beat");
        for (int k = 1; k <= 50; k++) begin
            tick = 1'b1;
            r_pulse = (k == 50);
            @(negedge clk);
        end
        tick = 1'b0;
        r_pulse = 1'b0;
        @(negedge clk);
        check_all("R10 frozen");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule